// File: doc/BRIEF.md
# Multiple-Capture HDR Pixel Combiner

This block merges a burst of captures of the same scene into one high dynamic range image. A fast sensor reads every pixel several times per output frame. The exposure time doubles from each capture to the next. The samples arrive as a stream: one 8-bit sample per cycle, tagged with its pixel index and capture index, in pixel order, one full pass per capture. For each pixel the block holds a small record in an internal RAM, written so that block RAM can be inferred. The record holds the sample chosen so far, the index of the capture it came from, a lock bit and a clip bit. The block reads and updates this record as the pixel goes by in each pass.

A sample counts as saturated when it reaches a programmable threshold. The usual setting is 255, full scale. A pixel keeps its newest unsaturated sample until it first saturates, and from then on it is frozen for the rest of the frame. During the pass flagged as the last capture, the block emits one result per pixel. The result is the chosen sample shifted left by the number of doublings between its capture and the last one, which puts every pixel on the linear scale of the longest exposure. A pixel that is already saturated in its first capture is emitted fully shifted, with a clip flag. Input is ignored until the first frame-start marker after reset.

Top module: `hdr_lsbs_combiner`

## Requirements
- R1: A sample is saturated when its value is greater than or equal to `sat_thresh`. Lowering the threshold makes smaller samples count as saturated.
- R2: For each pixel, the chosen sample is the one from the latest capture before the first saturated capture of the frame. Unsaturated samples that come after the first saturation are ignored.
- R3: `out_value` equals the chosen sample shifted left by (index of the capture flagged last minus the chosen capture index). The width is PIX_W + CAP_N - 1 bits (13 by default).
- R4: If a pixel's capture 0 is saturated, the result is that capture-0 sample shifted left by the last capture index, and `out_clip` is 1. Otherwise `out_clip` is 0.
- R5: Each accepted sample with `in_last_cap` high produces exactly one result. The result has `out_valid` high, `out_addr` equal to its pixel index, and appears two clock cycles after that sample is accepted. No other cycle has `out_valid` high.
- R6: A sample with capture index 0 starts the pixel over. Nothing chosen in an earlier frame affects the new result.
- R7: After reset, samples are discarded and produce no output until the first sample with `in_frame_start` high. That sample is itself accepted.
- R8: While `rst` is high and in the first cycle after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is present this cycle |
| in_pix | input | PIX_W | Sample value from the pixel ADC |
| in_addr | input | $clog2(NUM_PIX) | Pixel index of the sample |
| in_cap | input | $clog2(CAP_N) | Capture index, 0 = shortest exposure |
| in_frame_start | input | 1 | Marks the first sample of a frame |
| in_last_cap | input | 1 | The sample belongs to the final capture pass |
| sat_thresh | input | PIX_W | Saturation threshold |
| out_valid | output | 1 | Result strobe |
| out_addr | output | $clog2(NUM_PIX) | Pixel index of the result |
| out_value | output | PIX_W+CAP_N-1 | Linear HDR value |
| out_clip | output | 1 | Pixel saturated even at the shortest exposure |

## Verification
The bench builds the block with 16 pixels and six captures. At that size a whole frame of six passes takes only a few hundred cycles, so many frames fit in one run. Every shift from 0 to 5 and the full 13-bit output range can be reached. Random light levels are mixed with directed frames: all dark, all clipped, a lowered threshold, a four-capture frame with a shorter shift, a frame where a pixel dips back below the threshold after saturating, and a frame sent before any frame start.

// File: rtl/hdr_lsbs_pkg.sv
package hdr_lsbs_pkg;
  typedef enum logic [1:0] {
    DEC_INIT = 2'd0,  // capture 0: start the pixel over
    DEC_TAKE = 2'd1,  // unsaturated and not frozen: adopt sample
    DEC_LOCK = 2'd2,  // first saturation: freeze
    DEC_HOLD = 2'd3   // already frozen: keep record
  } dec_e;
endpackage

// File: rtl/hdr_state_ram.sv
module hdr_state_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 13,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/hdr_select.sv
module hdr_select
  import hdr_lsbs_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int CAP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [PIX_W-1:0] smp_pix,
  input  logic [CAP_W-1:0] smp_cap,
  input  logic [PIX_W-1:0] thresh,
  input  logic [PIX_W-1:0] old_pix,
  input  logic [CAP_W-1:0] old_cap,
  input  logic             old_lock,
  input  logic             old_clip,
  output logic [PIX_W-1:0] new_pix,
  output logic [CAP_W-1:0] new_cap,
  output logic             new_lock,
  output logic             new_clip,
  output dec_e             dec
);
  logic sat;

  always_comb begin
    sat = (smp_pix >= thresh);
    if (smp_cap == '0)   dec = DEC_INIT;
    else if (old_lock)   dec = DEC_HOLD;
    else if (sat)        dec = DEC_LOCK;
    else                 dec = DEC_TAKE;

    new_pix  = old_pix;
    new_cap  = old_cap;
    new_lock = old_lock;
    new_clip = old_clip;
    unique case (dec)
      DEC_INIT: begin
        new_pix  = smp_pix;
        new_cap  = '0;
        new_lock = sat;
        new_clip = sat;
      end
      DEC_TAKE: begin
        new_pix = smp_pix;
        new_cap = smp_cap;
      end
      DEC_LOCK: new_lock = 1'b1;
      default: ;
    endcase
  end

  AST_CHOSEN_UNSAT: assert property (@(posedge clk) disable iff (rst)
    (vld && dec == DEC_TAKE) |-> (new_pix < thresh)); // R2
  AST_CLIP_AT_CAP0: assert property (@(posedge clk) disable iff (rst)
    (vld && new_clip) |-> (new_cap == '0 && new_lock)); // R4
  AST_NO_REWIND: assert property (@(posedge clk) disable iff (rst)
    (vld && dec != DEC_INIT) |-> (new_cap >= old_cap)); // R2
endmodule

// File: rtl/hdr_scale.sv
module hdr_scale #(
  parameter int PIX_W  = 8,
  parameter int CAP_N  = 6,
  parameter int ADDR_W = 6,
  localparam int CAP_W = $clog2(CAP_N),
  localparam int OUT_W = PIX_W + CAP_N - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic [ADDR_W-1:0] emit_addr,
  input  logic [CAP_W-1:0]  last_cap,
  input  logic [PIX_W-1:0]  sel_pix,
  input  logic [CAP_W-1:0]  sel_cap,
  input  logic              sel_clip,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [OUT_W-1:0]  out_value,
  output logic              out_clip
);
  logic [CAP_W-1:0] shamt;
  logic [OUT_W-1:0] widened;

  always_comb begin
    shamt   = last_cap - sel_cap;
    widened = {{(OUT_W-PIX_W){1'b0}}, sel_pix};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_value <= '0;
      out_clip  <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_addr  <= emit_addr;
        out_value <= widened << shamt;
        out_clip  <= sel_clip;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    emit |-> (sel_cap <= last_cap && int'(last_cap) < CAP_N)); // R3
endmodule

// File: rtl/hdr_lsbs_combiner.sv
module hdr_lsbs_combiner
  import hdr_lsbs_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int CAP_N   = 6,
  parameter int NUM_PIX = 64,
  localparam int CAP_W  = $clog2(CAP_N),
  localparam int ADDR_W = $clog2(NUM_PIX),
  localparam int OUT_W  = PIX_W + CAP_N - 1,
  localparam int ST_W   = PIX_W + CAP_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CAP_W-1:0]  in_cap,
  input  logic              in_frame_start,
  input  logic              in_last_cap,
  input  logic [PIX_W-1:0]  sat_thresh,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [OUT_W-1:0]  out_value,
  output logic              out_clip
);
  logic              armed;
  logic              accept;
  logic              s1_vld, s1_last;
  logic [PIX_W-1:0]  s1_pix;
  logic [ADDR_W-1:0] s1_addr;
  logic [CAP_W-1:0]  s1_cap;
  logic [ST_W-1:0]   rd_state, wr_state;
  logic [PIX_W-1:0]  new_pix;
  logic [CAP_W-1:0]  new_cap;
  logic              new_lock, new_clip;
  dec_e              dec;

  assign accept = in_valid && (armed || in_frame_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      s1_pix  <= '0;
      s1_addr <= '0;
      s1_cap  <= '0;
    end else begin
      if (in_valid && in_frame_start) armed <= 1'b1;
      s1_vld  <= accept;
      s1_last <= accept && in_last_cap;
      if (accept) begin
        s1_pix  <= in_pix;
        s1_addr <= in_addr;
        s1_cap  <= in_cap;
      end
    end
  end

  // Record layout: {clip, lock, capture index, sample}
  hdr_state_ram #(.DEPTH(NUM_PIX), .WIDTH(ST_W)) u_ram (
    .clk     (clk),
    .rd_en   (accept),
    .rd_addr (in_addr),
    .rd_data (rd_state),
    .wr_en   (s1_vld),
    .wr_addr (s1_addr),
    .wr_data (wr_state)
  );

  hdr_select #(.PIX_W(PIX_W), .CAP_W(CAP_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .vld      (s1_vld),
    .smp_pix  (s1_pix),
    .smp_cap  (s1_cap),
    .thresh   (sat_thresh),
    .old_pix  (rd_state[PIX_W-1:0]),
    .old_cap  (rd_state[PIX_W +: CAP_W]),
    .old_lock (rd_state[ST_W-2]),
    .old_clip (rd_state[ST_W-1]),
    .new_pix  (new_pix),
    .new_cap  (new_cap),
    .new_lock (new_lock),
    .new_clip (new_clip),
    .dec      (dec)
  );

  assign wr_state = {new_clip, new_lock, new_cap, new_pix};

  hdr_scale #(.PIX_W(PIX_W), .CAP_N(CAP_N), .ADDR_W(ADDR_W)) u_scale (
    .clk       (clk),
    .rst       (rst),
    .emit      (s1_last),
    .emit_addr (s1_addr),
    .last_cap  (s1_cap),
    .sel_pix   (new_pix),
    .sel_cap   (new_cap),
    .sel_clip  (new_clip),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_value (out_value),
    .out_clip  (out_clip)
  );

  AST_OUT_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_last_cap, 2)); // R5
  AST_SILENT_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !out_valid); // R7
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R8
endmodule

// File: tb/tb_hdr_lsbs_combiner.sv
module tb_hdr_lsbs_combiner;
  localparam int PIX_W = 8;
  localparam int CAP_N = 6;
  localparam int NPIX  = 16;
  localparam int CAP_W = $clog2(CAP_N);
  localparam int AW    = $clog2(NPIX);
  localparam int OUT_W = PIX_W + CAP_N - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_frame_start = 1'b0, in_last_cap = 1'b0;
  logic [PIX_W-1:0] in_pix = '0;
  logic [AW-1:0] in_addr = '0;
  logic [CAP_W-1:0] in_cap = '0;
  logic [PIX_W-1:0] sat_thresh = 8'd255;
  logic out_valid, out_clip;
  logic [AW-1:0] out_addr;
  logic [OUT_W-1:0] out_value;

  always #5 clk = ~clk;

  hdr_lsbs_combiner #(.PIX_W(PIX_W), .CAP_N(CAP_N), .NUM_PIX(NPIX)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix), .in_addr(in_addr),
    .in_cap(in_cap), .in_frame_start(in_frame_start), .in_last_cap(in_last_cap),
    .sat_thresh(sat_thresh), .out_valid(out_valid), .out_addr(out_addr),
    .out_value(out_value), .out_clip(out_clip));

  int unsigned n_chk = 0, n_fail = 0, cyc = 0, got_cnt = 0;
  int unsigned last_cyc [NPIX];
  logic [PIX_W-1:0] smp [NPIX][CAP_N];
  logic [OUT_W-1:0] exp_val [NPIX];
  logic exp_clip [NPIX];
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Model from the requirements: newest unsaturated sample before first saturation.
  task automatic build_expect(input int ncap);
    for (int p = 0; p < NPIX; p++) begin
      int ch, cc; bit lock, clip;
      ch = smp[p][0]; cc = 0;
      lock = (smp[p][0] >= sat_thresh); clip = lock;
      for (int c = 1; c < ncap; c++) begin
        if (!lock) begin
          if (smp[p][c] >= sat_thresh) lock = 1'b1;
          else begin ch = smp[p][c]; cc = c; end
        end
      end
      exp_val[p]  = OUT_W'(ch << (ncap - 1 - cc));
      exp_clip[p] = clip;
    end
  endtask

  task automatic fill_random();
    for (int p = 0; p < NPIX; p++) begin
      int light = $urandom_range(1, 3000);
      for (int c = 0; c < CAP_N; c++) begin
        int v = (light << c) >> 4;
        smp[p][c] = (v > 255) ? 8'd255 : PIX_W'(v);
      end
    end
  endtask

  task automatic run_frame(input int ncap, input bit arm, input bit expect_out);
    got_cnt = 0;
    for (int c = 0; c < ncap; c++) begin
      for (int p = 0; p < NPIX; p++) begin
        int gap = ($urandom_range(0, 3) == 0) ? 1 : 0;
        if (gap != 0) begin
          @(negedge clk); in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1; in_pix = smp[p][c]; in_addr = AW'(p); in_cap = CAP_W'(c);
        in_frame_start = arm && c == 0 && p == 0;
        in_last_cap = (c == ncap - 1);
        if (c == ncap - 1) last_cyc[p] = cyc;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_frame_start = 1'b0; in_last_cap = 1'b0;
    repeat (4) @(negedge clk);
    if (expect_out) check(got_cnt == NPIX, "R5", "results per frame", got_cnt, NPIX);
    else            check(got_cnt == 0, "R7", "results before frame start", got_cnt, 0);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      got_cnt++;
      check(out_value == exp_val[out_addr], "R3", "value (R2 selection)", out_value, exp_val[out_addr]);
      check(out_clip == exp_clip[out_addr], "R4", "clip flag", out_clip, exp_clip[out_addr]);
      check(cyc == last_cyc[out_addr] + 2, "R5", "latency", cyc, last_cyc[out_addr] + 2);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);

    // R7: frame without frame start is dropped
    fill_random();
    run_frame(CAP_N, 1'b0, 1'b0);

    // R2/R3: all dark, every pixel from the last capture
    for (int p = 0; p < NPIX; p++)
      for (int c = 0; c < CAP_N; c++) smp[p][c] = PIX_W'(p * 3 + c);
    build_expect(CAP_N); run_frame(CAP_N, 1'b1, 1'b1);

    // R4: all saturated at capture 0
    for (int p = 0; p < NPIX; p++)
      for (int c = 0; c < CAP_N; c++) smp[p][c] = 8'd255;
    build_expect(CAP_N); run_frame(CAP_N, 1'b1, 1'b1);

    // R6: dark frame right after clipped frame, no carryover
    for (int p = 0; p < NPIX; p++)
      for (int c = 0; c < CAP_N; c++) smp[p][c] = PIX_W'(10 + p);
    build_expect(CAP_N); run_frame(CAP_N, 1'b1, 1'b1);

    // R2: dip below threshold after saturation is ignored
    fill_random();
    smp[3][0] = 8'd40; smp[3][1] = 8'd90; smp[3][2] = 8'd255; smp[3][3] = 8'd20;
    smp[3][4] = 8'd30; smp[3][5] = 8'd50;
    build_expect(CAP_N); run_frame(CAP_N, 1'b1, 1'b1);

    // R1: lowered threshold, value equal to threshold saturates
    fill_random();
    sat_thresh = 8'd100;
    smp[5][0] = 8'd60; smp[5][1] = 8'd99; smp[5][2] = 8'd100;
    smp[6][0] = 8'd100;
    build_expect(CAP_N); run_frame(CAP_N, 1'b1, 1'b1);
    sat_thresh = 8'd255;

    // R3: shorter frame of four captures
    fill_random();
    build_expect(4); run_frame(4, 1'b1, 1'b1);

    // Random frames with random thresholds
    for (int f = 0; f < 6; f++) begin
      fill_random();
      sat_thresh = PIX_W'($urandom_range(150, 255));
      build_expect(CAP_N); run_frame(CAP_N, 1'b1, 1'b1);
    end
    finish_run();
  end
endmodule